// File: doc/BRIEF.md
# ADC Serial Power-Mode Sequencer

This block is the digital power-mode controller of a serially programmed analog-to-digital converter. It watches a serial data line clocked by an external serial clock while an active-low select is held low. It finds a start bit and assembles an 8-bit control word. From the two lowest bits of that word it decides whether the converter runs with an external or an internal conversion clock, or drops into one of two software power-down levels once the next conversion is done.

A power state machine keeps the converter powered, waking, converting or shut down. When a start bit arrives in a power-down state, the machine counts a wake-up delay in system-clock cycles before any conversion can begin. The delay is short when only the fast level was active and long when the full level was. A hard shutdown input overrides everything and holds full power-down. The analog conversion itself is modelled by a fixed-length interval that ends with a one-cycle done pulse. The serial intake runs in every power state.

Top module: `adc_pwr_seq`

## Requirements
- R1: At a rising serial-clock edge while `cs_n` is low, the first 1 on `sdi` is taken as the start bit and leading zeros are skipped. The word completes on the eighth rising edge, counting the start-bit edge, and the start bit is its MSB. The mode code is the last two bits shifted in (bit 1 first, then bit 0). Intake works in every power state.
- R2: Mode code 11 sets `ext_clk`=1 and code 10 sets `ext_clk`=0; after their conversion the converter stays powered (`pwr_state`=3). Code 01 ends in fast power-down (`pwr_state`=1) and code 00 in full power-down (`pwr_state`=0). Both power-down codes leave `ext_clk` at the last clock mode.
- R3: Every completed word starts exactly one conversion. During it `pwr_state`=4 for `CONV_CYCLES` cycles, and `conv_done` pulses once as it ends. A requested power-down takes effect only after that.
- R4: A start bit in a power-down state moves to `pwr_state`=2 (waking) for `WAKE_FAST` cycles from fast or `WAKE_FULL` cycles from full power-down. A start bit in a powered state does not restart the wake.
- R5: No conversion begins from a power-down state. A word that completes while waking starts its conversion when the wake delay ends.
- R6: Raising `cs_n` before the eighth edge discards the partial word. Neither the mode nor the power state changes, and no conversion runs.
- R7: While `shdn` is high the block is in full power-down (`pwr_state`=0) from the next cycle on, and start bits and words change no power state. After `shdn` falls it stays there until a new start bit.
- R8: After reset `pwr_state`=0, `ext_clk`=0 (internal clock recorded), and `busy`, `pwr_on` and `conv_done` are 0.
- R9: `busy` is high exactly while waking or converting. `pwr_on` is high in the waking, powered and converting states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock, sampled in the system clock domain |
| cs_n | input | 1 | Active-low serial select |
| sdi | input | 1 | Serial data in |
| shdn | input | 1 | Hard shutdown, active high |
| pwr_on | output | 1 | Converter supplied (waking, powered or converting) |
| pwr_state | output | 3 | 0 full off, 1 fast off, 2 waking, 3 powered, 4 converting |
| ext_clk | output | 1 | Recorded clock mode: 1 external, 0 internal |
| busy | output | 1 | Waking or converting |
| conv_done | output | 1 | One-cycle pulse at the end of a conversion |

## Verification
The assertions assume that `sclk`, `cs_n` and `sdi` change slowly compared with the system clock. Each serial-clock level must last at least two system cycles so that the synchronizer sees every edge, and `sdi` must be stable around each rising edge. The stimulus holds each serial-clock phase for four system cycles and changes `sdi` only while the serial clock is low. It raises `cs_n` between words, so each word begins with a fresh search for the start bit. `shdn` is driven directly on system-clock boundaries, and the shutdown assertion relies on it being synchronous to `clk`.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;
  typedef enum logic [2:0] {
    PS_OFF_FULL = 3'd0,
    PS_OFF_FAST = 3'd1,
    PS_WAKING   = 3'd2,
    PS_READY    = 3'd3,
    PS_CONV     = 3'd4
  } pwr_st_t;

  localparam int CTL_BITS = 8;
endpackage

// File: rtl/adc_ctl_rx.sv
module adc_ctl_rx
  import adc_pwr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sclk,
  input  logic                cs_n,
  input  logic                sdi,
  output logic                start_stb,
  output logic                word_stb,
  output logic [CTL_BITS-1:0] ctl_word
);
  localparam int CW = $clog2(CTL_BITS);

  logic [2:0] sync_q [SYNC_STAGES];
  logic       sclk_d;
  logic       active;
  logic [CW-1:0] bit_cnt;
  logic [CTL_BITS-1:0] shreg;

  // Synchronizer chain for sclk, cs_n, sdi
  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[g] <= 3'b010;
          else     sync_q[g] <= {sclk, cs_n, sdi};
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_q[g] <= 3'b010;
          else     sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  logic s_sclk, s_cs_n, s_sdi, rise;
  assign s_sclk = sync_q[SYNC_STAGES-1][2];
  assign s_cs_n = sync_q[SYNC_STAGES-1][1];
  assign s_sdi  = sync_q[SYNC_STAGES-1][0];
  assign rise   = s_sclk & ~sclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d    <= 1'b0;
      active    <= 1'b0;
      bit_cnt   <= '0;
      shreg     <= '0;
      start_stb <= 1'b0;
      word_stb  <= 1'b0;
      ctl_word  <= '0;
    end else begin
      sclk_d    <= s_sclk;
      start_stb <= 1'b0;
      word_stb  <= 1'b0;
      if (s_cs_n) begin
        active  <= 1'b0;
        bit_cnt <= '0;
      end else if (rise) begin
        if (!active) begin
          if (s_sdi) begin
            active    <= 1'b1;
            bit_cnt   <= CW'(1);
            shreg     <= CTL_BITS'(1);
            start_stb <= 1'b1;
          end
        end else begin
          shreg   <= {shreg[CTL_BITS-2:0], s_sdi};
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == CW'(CTL_BITS-1)) begin
            word_stb <= 1'b1;
            ctl_word <= {shreg[CTL_BITS-2:0], s_sdi};
            active   <= 1'b0;
            bit_cnt  <= '0;
          end
        end
      end
    end
  end

  // R1: a start and a word completion never coincide
  assert_strobe_excl_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({start_stb, word_stb}));

  // R6: a word only completes while the select was low
  assert_word_needs_select_R6: assert property (@(posedge clk) disable iff (rst)
    word_stb |-> $past(!s_cs_n));

  // R1: completed word always carries the start bit as MSB
  assert_word_msb_R1: assert property (@(posedge clk) disable iff (rst)
    word_stb |-> ctl_word[CTL_BITS-1]);
endmodule

// File: rtl/adc_pwr_fsm.sv
module adc_pwr_fsm
  import adc_pwr_pkg::*;
#(
  parameter int WAKE_FAST   = 625,
  parameter int WAKE_FULL   = 37500,
  parameter int CONV_CYCLES = 200
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       shdn,
  input  logic       start_stb,
  input  logic       word_stb,
  input  logic [1:0] mode_code,
  output pwr_st_t    state,
  output logic       ext_clk,
  output logic       busy,
  output logic       pwr_on,
  output logic       conv_done
);
  localparam int MAXD = (WAKE_FULL > WAKE_FAST) ?
                        ((WAKE_FULL > CONV_CYCLES) ? WAKE_FULL : CONV_CYCLES) :
                        ((WAKE_FAST > CONV_CYCLES) ? WAKE_FAST : CONV_CYCLES);
  localparam int TW   = $clog2(MAXD + 1);

  pwr_st_t       st_n;
  logic [TW-1:0] tmr, tmr_n;
  logic          pend, pend_n;
  logic          stay, stay_n;
  logic          fast, fast_n;
  logic          ext_n, done_n;

  always_comb begin
    st_n   = state;
    tmr_n  = tmr;
    pend_n = pend;
    stay_n = stay;
    fast_n = fast;
    ext_n  = ext_clk;
    done_n = 1'b0;
    if (word_stb) begin
      if (mode_code[1]) begin
        ext_n  = mode_code[0];
        stay_n = 1'b1;
      end else begin
        stay_n = 1'b0;
        fast_n = mode_code[0];
      end
    end
    if (shdn) begin
      st_n   = PS_OFF_FULL;
      pend_n = 1'b0;
    end else begin
      unique case (state)
        PS_OFF_FULL, PS_OFF_FAST: begin
          if (start_stb) begin
            st_n  = PS_WAKING;
            tmr_n = (state == PS_OFF_FAST) ? TW'(WAKE_FAST - 1) : TW'(WAKE_FULL - 1);
          end
        end
        PS_WAKING: begin
          if (word_stb) pend_n = 1'b1;
          if (tmr == '0) begin
            if (pend || word_stb) begin
              st_n   = PS_CONV;
              tmr_n  = TW'(CONV_CYCLES - 1);
              pend_n = 1'b0;
            end else begin
              st_n = PS_READY;
            end
          end else begin
            tmr_n = tmr - 1'b1;
          end
        end
        PS_READY: begin
          if (word_stb) begin
            st_n  = PS_CONV;
            tmr_n = TW'(CONV_CYCLES - 1);
          end
        end
        PS_CONV: begin
          if (word_stb) pend_n = 1'b1;
          if (tmr == '0) begin
            done_n = 1'b1;
            if (pend || word_stb) begin
              tmr_n  = TW'(CONV_CYCLES - 1);
              pend_n = 1'b0;
            end else if (stay_n) begin
              st_n = PS_READY;
            end else begin
              st_n = fast_n ? PS_OFF_FAST : PS_OFF_FULL;
            end
          end else begin
            tmr_n = tmr - 1'b1;
          end
        end
        default: st_n = PS_OFF_FULL;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= PS_OFF_FULL;
      tmr       <= '0;
      pend      <= 1'b0;
      stay      <= 1'b0;
      fast      <= 1'b0;
      ext_clk   <= 1'b0;
      conv_done <= 1'b0;
      busy      <= 1'b0;
      pwr_on    <= 1'b0;
    end else begin
      state     <= st_n;
      tmr       <= tmr_n;
      pend      <= pend_n;
      stay      <= stay_n;
      fast      <= fast_n;
      ext_clk   <= ext_n;
      conv_done <= done_n;
      busy      <= (st_n == PS_WAKING) || (st_n == PS_CONV);
      pwr_on    <= (st_n == PS_WAKING) || (st_n == PS_READY) || (st_n == PS_CONV);
    end
  end

  // R7: hard shutdown forces full power-down on the next cycle
  assert_shdn_off_R7: assert property (@(posedge clk) disable iff (rst)
    shdn |=> (state == PS_OFF_FULL));

  // R5: a conversion is only entered from a powered or waking state
  assert_no_conv_from_off_R5: assert property (@(posedge clk) disable iff (rst)
    ((state == PS_CONV) && ($past(state) != PS_CONV)) |->
      (($past(state) == PS_READY) || ($past(state) == PS_WAKING)));

  // R3: done pulse only follows a conversion cycle
  assert_done_after_conv_R3: assert property (@(posedge clk) disable iff (rst)
    conv_done |-> ($past(state) == PS_CONV));

  // R3: leaving a conversion without shutdown means it finished
  assert_pd_deferred_R3: assert property (@(posedge clk) disable iff (rst)
    (($past(state) == PS_CONV) && (state != PS_CONV) && !$past(shdn)) |-> conv_done);

  // R4: a start bit in power-down begins the wake sequence
  assert_start_wakes_R4: assert property (@(posedge clk) disable iff (rst)
    (start_stb && !shdn && ((state == PS_OFF_FULL) || (state == PS_OFF_FAST)))
      |=> (state == PS_WAKING));

  // R9: busy and supply flags agree with the state register
  assert_busy_flags_R9: assert property (@(posedge clk) disable iff (rst)
    busy |-> pwr_on);
endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq
  import adc_pwr_pkg::*;
#(
  parameter int WAKE_FAST   = 625,
  parameter int WAKE_FULL   = 37500,
  parameter int CONV_CYCLES = 200,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sclk,
  input  logic       cs_n,
  input  logic       sdi,
  input  logic       shdn,
  output logic       pwr_on,
  output logic [2:0] pwr_state,
  output logic       ext_clk,
  output logic       busy,
  output logic       conv_done
);
  logic                start_stb, word_stb;
  logic [CTL_BITS-1:0] ctl_word;
  pwr_st_t             st;

  adc_ctl_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .sclk     (sclk),
    .cs_n     (cs_n),
    .sdi      (sdi),
    .start_stb(start_stb),
    .word_stb (word_stb),
    .ctl_word (ctl_word)
  );

  adc_pwr_fsm #(
    .WAKE_FAST  (WAKE_FAST),
    .WAKE_FULL  (WAKE_FULL),
    .CONV_CYCLES(CONV_CYCLES)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .shdn     (shdn),
    .start_stb(start_stb),
    .word_stb (word_stb),
    .mode_code(ctl_word[1:0]),
    .state    (st),
    .ext_clk  (ext_clk),
    .busy     (busy),
    .pwr_on   (pwr_on),
    .conv_done(conv_done)
  );

  assign pwr_state = st;
endmodule

// File: tb/adc_pwr_seq_test.sv
module adc_pwr_seq_test;
  localparam int WF = 6;
  localparam int WL = 30;
  localparam int CC = 10;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0, shdn = 1'b0;
  logic pwr_on, ext_clk, busy, conv_done;
  logic [2:0] pwr_state;

  always #4 clk = ~clk;

  adc_pwr_seq #(.WAKE_FAST(WF), .WAKE_FULL(WL), .CONV_CYCLES(CC)) uut (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .sdi(sdi), .shdn(shdn),
    .pwr_on(pwr_on), .pwr_state(pwr_state), .ext_clk(ext_clk),
    .busy(busy), .conv_done(conv_done)
  );

  int n_chk = 0, n_fail = 0;
  int wake_cyc = 0, conv_cyc = 0, done_cnt = 0, busy_cyc = 0;
  logic mon_clr = 1'b0;

  always @(negedge clk) begin
    if (mon_clr) begin
      wake_cyc <= 0; conv_cyc <= 0; done_cnt <= 0; busy_cyc <= 0;
    end else if (!rst) begin
      if (pwr_state == 3'd2) wake_cyc <= wake_cyc + 1;
      if (pwr_state == 3'd4) conv_cyc <= conv_cyc + 1;
      if (conv_done) done_cnt <= done_cnt + 1;
      if (busy) busy_cyc <= busy_cyc + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    @(negedge clk) mon_clr = 1'b1;
    @(negedge clk) mon_clr = 1'b0;
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_bits(input logic [15:0] bits, input int nb, input bit keep_low);
    @(negedge clk) cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = nb - 1; i >= 0; i--) begin
      sdi = bits[i];
      wait_clk(HALF);
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
    wait_clk(HALF);
    if (!keep_low) cs_n = 1'b1;
    sdi = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 400 && done_cnt == 0; i++) @(negedge clk);
    wait_clk(3);
  endtask

  // code[13:12], wake cycles[11:4], final state[3:1], ext_clk[0]
  localparam logic [13:0] VEC [0:7] = '{
    {2'b00, 8'd30, 3'd0, 1'b0},
    {2'b11, 8'd30, 3'd3, 1'b1},
    {2'b10, 8'd0,  3'd3, 1'b0},
    {2'b01, 8'd0,  3'd1, 1'b0},
    {2'b11, 8'd6,  3'd3, 1'b1},
    {2'b00, 8'd0,  3'd0, 1'b1},
    {2'b01, 8'd30, 3'd1, 1'b1},
    {2'b10, 8'd6,  3'd3, 1'b0}
  };

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait_clk(4);
    rst = 1'b0;
    wait_clk(2);
    // R8 reset state
    check("R8 state", pwr_state, 0);
    check("R8 ext_clk", ext_clk, 0);
    check("R8 busy", busy, 0);
    check("R8 pwr_on", pwr_on, 0);
    check("R8 conv_done", conv_done, 0);

    // R1 R2 R3 R4 R5: vector walk, three leading zeros before each start bit
    for (int v = 0; v < 8; v++) begin
      clear_mon();
      send_bits({5'b0, 3'b000, 6'b100000, VEC[v][13:12]}, 11, 1'b0);
      wait_done();
      check($sformatf("R2 v%0d state", v), pwr_state, int'(VEC[v][3:1]));
      check($sformatf("R2 v%0d ext_clk", v), ext_clk, int'(VEC[v][0]));
      check($sformatf("R4 v%0d wake cycles", v), wake_cyc, int'(VEC[v][11:4]));
      check($sformatf("R3 v%0d conv cycles", v), conv_cyc, CC);
      check($sformatf("R3 v%0d done pulses", v), done_cnt, 1);
      check($sformatf("R9 v%0d busy cycles", v), busy_cyc, int'(VEC[v][11:4]) + CC);
    end
    // R9 powered after last vector
    check("R9 pwr_on powered", pwr_on, 1);
    check("R9 busy idle", busy, 0);

    // R6: partial word then select released
    clear_mon();
    send_bits(16'h000F, 4, 1'b0);
    wait_clk(30);
    check("R6 state", pwr_state, 3);
    check("R6 ext_clk", ext_clk, 0);
    check("R6 no conversion", done_cnt, 0);
    check("R4 no rewake when powered", wake_cyc, 0);

    // R7: hard shutdown
    clear_mon();
    shdn = 1'b1;
    wait_clk(2);
    check("R7 state", pwr_state, 0);
    check("R7 pwr_on", pwr_on, 0);
    send_bits(16'h0083, 8, 1'b0);
    wait_clk(30);
    check("R7 still off", pwr_state, 0);
    check("R7 no wake", wake_cyc, 0);
    check("R7 no conversion", done_cnt, 0);
    shdn = 1'b0;
    wait_clk(20);
    check("R7 off after release", pwr_state, 0);

    // R1 R4: wake from full after shutdown, external clock
    clear_mon();
    send_bits(16'h0083, 8, 1'b0);
    wait_done();
    check("R4 wake full after shdn", wake_cyc, WL);
    check("R2 ext after shdn", ext_clk, 1);
    check("R2 powered after shdn", pwr_state, 3);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule